// File: doc/BRIEF.md
# Stereo Gain Stream Stage

This block scales a stream of stereo audio samples by a per-channel gain and passes the result downstream over AXI-Stream. Every 32-bit beat holds two signed 16-bit samples: the left channel in the low half and the right channel in the high half. Each sample is multiplied by a signed gain with 12 fractional bits. The product is shifted back to sample scale and clamped to the 16-bit range, so loud inputs clip instead of wrapping.

The datapath has two register stages: the scaling stage and an output stage. One shared advance condition moves both stages together. Downstream backpressure therefore freezes the whole pipeline, and no beat is lost, duplicated or reordered. When the pipeline is not stalled, every beat comes out exactly two clock edges after it is accepted, whatever its sample or gain values. A scale-enable input selects bypass: the samples pass through unchanged but take the same two-stage path.

Top module: `stereo_gain_stream`

## Requirements
- R1: Input and output beats are 32 bits wide. Bits [15:0] hold the left sample and bits [31:16] hold the right sample, both two's complement.
- R2: With `scale_en` high, each output sample equals floor(sample × gain / 4096). The gain is a signed 16-bit value in which 0x1000 means 1.0 and 0x8000 means −8.0. `gain_left` applies to bits [15:0] and `gain_right` to bits [31:16].
- R3: A scaled result above 32767 becomes 0x7FFF, and a result below −32768 becomes 0x8000.
- R4: With `scale_en` low, the output beat equals the input beat bit for bit, whatever the gains are.
- R5: A beat accepted at clock edge t appears on `m_tvalid`/`m_tdata` after edge t+2 when no stall occurs, and `m_tvalid` stays low after edge t+1. This holds for any sample or gain value.
- R6: `s_tready` is high when the output stage is empty or `m_tready` is high, and low while the output holds a beat that is refused.
- R7: While `m_tvalid` is high and `m_tready` is low, `m_tdata`, `m_tvalid` and `m_tlast` keep their values into the next cycle.
- R8: Every accepted beat leaves the block exactly once and in acceptance order, under any pattern of input bubbles and downstream stalls.
- R9: `m_tlast` leaves the block with the same beat that carried `s_tlast`.
- R10: The active-low asynchronous reset `rst_n` clears both stage valid flags. After reset `m_tvalid` is 0 and `s_tready` is 1.
- R11: The gains and `scale_en` are sampled in the cycle a beat is accepted. Later changes do not alter a beat already inside the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| scale_en | input | 1 | 1 = apply gains, 0 = pass samples unchanged |
| gain_left | input | 16 | Signed left gain, 12 fractional bits |
| gain_right | input | 16 | Signed right gain, 12 fractional bits |
| s_tdata | input | 32 | Input stereo beat |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Block can accept a beat |
| s_tlast | input | 1 | Input packet boundary flag |
| m_tdata | output | 32 | Output stereo beat |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream can accept a beat |
| m_tlast | output | 1 | Output packet boundary flag |

## Verification
The delicate cycle is the one in which the output stage hands a beat downstream while a new beat is accepted at the input. Both stages must shift together in that cycle, with no gap and no repeated beat. The bench provokes it with a streaming run in which the downstream ready follows a fixed duty pattern and the input has periodic bubbles, so hand-off and accept coincide many times, often right after a stall is released. Every output transfer is compared in order against the beat sequence that was sent. During each stall the bench checks that the held output stays stable and that the input is refused.

// File: rtl/stereo_gain_stream.sv
module stereo_gain_stream #(
  parameter int SAMPLE_W  = 16,
  parameter int GAIN_W    = 16,
  parameter int GAIN_FRAC = 12,
  localparam int CHANNELS = 2,
  localparam int DATA_W   = SAMPLE_W * CHANNELS,
  localparam int PROD_W   = SAMPLE_W + GAIN_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scale_en,
  input  logic [GAIN_W-1:0] gain_left,
  input  logic [GAIN_W-1:0] gain_right,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic              s_tlast,
  output logic [DATA_W-1:0] m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast
);

  localparam logic signed [PROD_W-1:0] SAT_MAX = PROD_W'((1 << (SAMPLE_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] SAT_MIN = ~SAT_MAX;

  logic              advance;
  logic [DATA_W-1:0] scaled;
  logic [DATA_W-1:0] core_q;
  logic              core_v;
  logic              core_l;

  assign advance  = !m_tvalid || m_tready;
  assign s_tready = advance;

  for (genvar ch = 0; ch < CHANNELS; ch++) begin : g_chan
    logic signed [SAMPLE_W-1:0] smp;
    logic signed [GAIN_W-1:0]   gn;
    logic signed [PROD_W-1:0]   prod;
    logic signed [PROD_W-1:0]   shr;
    logic        [SAMPLE_W-1:0] clipped;

    assign smp  = s_tdata[ch*SAMPLE_W +: SAMPLE_W];
    assign gn   = (ch == 0) ? gain_left : gain_right;
    assign prod = smp * gn;
    assign shr  = prod >>> GAIN_FRAC;

    assign clipped = (shr > SAT_MAX) ? SAT_MAX[SAMPLE_W-1:0] :
                     (shr < SAT_MIN) ? SAT_MIN[SAMPLE_W-1:0] :
                                       shr[SAMPLE_W-1:0];

    assign scaled[ch*SAMPLE_W +: SAMPLE_W] = scale_en ? clipped : smp;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      core_q   <= '0;
      core_v   <= 1'b0;
      core_l   <= 1'b0;
      m_tdata  <= '0;
      m_tvalid <= 1'b0;
      m_tlast  <= 1'b0;
    end else if (advance) begin
      core_q   <= scaled;
      core_v   <= s_tvalid;
      core_l   <= s_tlast;
      m_tdata  <= core_q;
      m_tvalid <= core_v;
      m_tlast  <= core_l;
    end
  end

  // R7: a refused output beat is held unchanged
  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  // R6: the input is refused while the output is stalled
  p_stall_blocks_input_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |-> !s_tready);

  // R5: an accepted beat followed by a free cycle is on the output two edges later
  p_two_stage_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready) ##1 (!m_tvalid || m_tready) |=> m_tvalid);

  // R9: last flag follows its beat through both stages
  p_last_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && s_tlast) ##1 (!m_tvalid || m_tready) |=> m_tlast);

  // R8: the output valid can only rise when the pipeline moves
  p_valid_rises_on_move_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_tvalid) |-> $past(s_tready));

endmodule

// File: tb/stereo_gain_stream_tb_top.sv
`timescale 1ns/1ps
module stereo_gain_stream_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scale_en = 1'b1;
  logic [15:0] gain_left = 16'h1000;
  logic [15:0] gain_right = 16'h1000;
  logic [31:0] s_tdata = '0;
  logic        s_tvalid = 1'b0;
  logic        s_tready;
  logic        s_tlast = 1'b0;
  logic [31:0] m_tdata;
  logic        m_tvalid;
  logic        m_tready = 1'b1;
  logic        m_tlast;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  stereo_gain_stream dut_i (
    .clk(clk), .rst_n(rst_n), .scale_en(scale_en),
    .gain_left(gain_left), .gain_right(gain_right),
    .s_tdata(s_tdata), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tlast(s_tlast),
    .m_tdata(m_tdata), .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tlast(m_tlast)
  );

  // {sample, gain, expected}
  localparam logic [47:0] VEC [10] = '{
    {16'h03E8, 16'h1000, 16'h03E8},
    {16'h03E8, 16'h2000, 16'h07D0},
    {16'hFC18, 16'h0800, 16'hFE0C},
    {16'h4E20, 16'h2000, 16'h7FFF},
    {16'hB1E0, 16'h2000, 16'h8000},
    {16'h0003, 16'h0800, 16'h0001},
    {16'hFFFD, 16'h0800, 16'hFFFE},
    {16'h7FFF, 16'h8000, 16'h8000},
    {16'h8000, 16'h8000, 16'h7FFF},
    {16'h3039, 16'h0000, 16'h0000}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(int k);
    return 32'h1000_0000 + 32'(k) * 32'h0001_0003;
  endfunction

  initial begin
    #(8 * 200000);
    tests++;
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    // R10: reset state
    repeat (3) @(negedge clk);
    check(m_tvalid == 1'b0, "R10 valid in reset", 32'(m_tvalid), 32'd0);
    check(s_tready == 1'b1, "R10 ready in reset", 32'(s_tready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R5: vector table
    for (int i = 0; i < 10; i++) begin
      int j;
      j = 9 - i;
      @(negedge clk);
      s_tdata    = {VEC[j][47:32], VEC[i][47:32]};
      gain_left  = VEC[i][31:16];
      gain_right = VEC[j][31:16];
      s_tlast    = i[0];
      s_tvalid   = 1'b1;
      m_tready   = 1'b1;
      #1;
      check(s_tready == 1'b1, "R6 ready when empty", 32'(s_tready), 32'd1);
      @(negedge clk);
      s_tvalid  = 1'b0;
      // R11: change gains after acceptance
      gain_left  = 16'h7777;
      gain_right = 16'h7777;
      #1;
      check(m_tvalid == 1'b0, "R5 not early", 32'(m_tvalid), 32'd0);
      @(negedge clk);
      #1;
      check(m_tvalid == 1'b1, "R5 two-edge latency", 32'(m_tvalid), 32'd1);
      check(m_tdata == {VEC[j][15:0], VEC[i][15:0]}, "R2 R3 R11 scaled pair",
            m_tdata, {VEC[j][15:0], VEC[i][15:0]});
      check(m_tlast == i[0], "R9 last per beat", 32'(m_tlast), 32'(i[0]));
    end

    // R4: bypass
    @(negedge clk);
    scale_en   = 1'b0;
    gain_left  = 16'h8000;
    gain_right = 16'h2000;
    s_tdata    = 32'h8000_7FFF;
    s_tvalid   = 1'b1;
    @(negedge clk);
    s_tvalid = 1'b0;
    scale_en = 1'b1;
    @(negedge clk);
    #1;
    check(m_tvalid && m_tdata == 32'h8000_7FFF, "R4 bypass", m_tdata, 32'h8000_7FFF);

    // R6 R7 R8 R9: streaming with stalls and bubbles
    begin
      int in_idx = 0;
      int out_idx = 0;
      bit held = 1'b0;
      logic [31:0] prev_d = '0;
      logic prev_l = 1'b0;
      scale_en = 1'b0;
      for (int c = 0; c < 2000 && out_idx < 40; c++) begin
        @(negedge clk);
        m_tready = (c % 7) < 4;
        s_tvalid = (in_idx < 40) && (c % 5 != 2);
        s_tdata  = pat(in_idx);
        s_tlast  = (in_idx % 5) == 4;
        #1;
        if (held)
          check(m_tvalid && m_tdata == prev_d && m_tlast == prev_l, "R7 hold", m_tdata, prev_d);
        if (m_tvalid && !m_tready)
          check(!s_tready, "R6 refuse on stall", 32'(s_tready), 32'd0);
        if (m_tvalid && m_tready) begin
          check(m_tdata == pat(out_idx), "R8 order", m_tdata, pat(out_idx));
          check(m_tlast == ((out_idx % 5) == 4), "R9 last", 32'(m_tlast), 32'((out_idx % 5) == 4));
          out_idx++;
        end
        if (s_tvalid && s_tready) in_idx++;
        held   = m_tvalid && !m_tready;
        prev_d = m_tdata;
        prev_l = m_tlast;
      end
      @(negedge clk);
      s_tvalid = 1'b0;
      m_tready = 1'b1;
      check(out_idx == 40, "R8 all beats out", 32'(out_idx), 32'd40);
      repeat (3) @(negedge clk);
      #1;
      check(m_tvalid == 1'b0, "R8 no duplicate", 32'(m_tvalid), 32'd0);
    end

    // R10: reset while the output is stalled
    @(negedge clk);
    m_tready = 1'b0;
    s_tvalid = 1'b1;
    s_tdata  = 32'h1234_5678;
    repeat (3) @(negedge clk);
    s_tvalid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(m_tvalid == 1'b0, "R10 reset clears", 32'(m_tvalid), 32'd0);
    check(s_tready == 1'b1, "R10 ready after reset", 32'(s_tready), 32'd1);
    @(negedge clk);
    rst_n = 1'b1;
    m_tready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(m_tvalid == 1'b0, "R10 nothing left", 32'(m_tvalid), 32'd0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule